// File: doc/BRIEF.md
# Interrupt Status and Coalescing Controller

This block collects interrupt causes from a network interface and drives a single interrupt line to the CPU. Internal sources post cause bits into a 32-bit status register. Software removes causes by writing ones to clear them. Software also selects which causes may reach the CPU through a mask register, and can turn the CPU line on or off with a global enable.

Non-urgent causes are held back for a programmable number of cycles. A new delayed request is folded into any request that is already scheduled to fire earlier. Urgent causes bypass the delay. Two watermark causes need a re-arm before they can be forwarded: receive-high re-arms when the receive FIFO is seen empty, and transmit-low re-arms when the transmit FIFO is seen full. The line is raised at most once until software acknowledges it by reading status.

Cause bits: 0 soft, 1 rx packet, 2 rx high, 3 rx empty, 4 rx DMA, 5 tx packet, 6 tx low, 7 tx full, 8 tx DMA. Bits 31:9 are reserved. The urgent (no-delay) causes are bits 0 and 7.

Top module: `irq_coalesce_ctrl`

## Requirements
- R1: A post ORs the non-reserved posted bits into status. Status bits 31:9 always read zero. A post or clear that touches bits 31:9 drives rsv_err_o high for exactly the one cycle after that edge.
- R2: A clear write resets exactly the status bits written as one. The remaining bits are kept.
- R3: After reset, status is 0, the mask is 0x0000_0047 (soft, rx packet, rx high, tx low), irq_o is 0, the global enable is off, receive-high is armed and transmit-low is not armed.
- R4: irq_o is only raised while status AND mask is nonzero and the global enable is on. Posts made while the enable is off do not raise it. Turning the enable on while status AND mask is nonzero raises irq_o at that same edge.
- R5: Receive-high (bit 2) is forwarded only while armed. Forwarding it disarms it, and an rx_fifo_empty_ev pulse re-arms it. A post whose only masked cause is a disarmed receive-high leaves irq_o low, but the bit is still recorded in status.
- R6: Transmit-low (bit 6) follows the same rule as R5. It is re-armed by tx_fifo_full_ev.
- R7: A post whose forwarded causes include no urgent bit (0 or 7) raises irq_o dly_cycles edges after the posting edge. A post with an urgent bit, or made with dly_cycles of 0, raises irq_o at the posting edge.
- R8: A delayed request that would fire later than one already scheduled is merged into the earlier one. A request that would fire sooner replaces the scheduled one.
- R9: A status read clears irq_o at that edge and leaves status unchanged. While irq_o is high, further requests do not produce a second rising edge.
- R10: A clear, a mask write or turning the enable off that leaves status AND mask at zero (or the enable off) drops irq_o at that edge. A mask write that changes the mask and leaves status AND mask nonzero raises irq_o at that edge.
- R11: A cmd_soft pulse posts the soft cause, bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_post_valid | input | 1 | Internal source posts causes this cycle |
| src_post_bits | input | 32 | Cause bits being posted |
| cmd_soft | input | 1 | Command write with the interrupt bit set |
| sw_clr_we | input | 1 | Software clear write strobe |
| sw_clr_data | input | 32 | Ones mark the status bits to clear |
| sw_mask_we | input | 1 | Software mask write strobe |
| sw_mask_data | input | 32 | New mask value |
| sw_ien_we | input | 1 | Global enable write strobe |
| sw_ien_data | input | 1 | New global enable value |
| sw_stat_rd | input | 1 | Status read; acts as the acknowledge |
| rx_fifo_empty_ev | input | 1 | Pulse: receive FIFO observed empty |
| tx_fifo_full_ev | input | 1 | Pulse: transmit FIFO observed full |
| dly_cycles | input | 16 | Coalescing delay in cycles |
| stat_o | output | 32 | Raw status register |
| mask_o | output | 32 | Mask register |
| irq_o | output | 1 | CPU interrupt line (registered) |
| rsv_err_o | output | 1 | Reserved-bit access flag |

## Verification
Every result is registered. Status, mask, the reserved flag and every immediate change of irq_o can be seen right after the edge that samples the stimulus. A delayed rise appears exactly dly_cycles edges after the posting edge. The bench drives each stimulus for one edge and samples one time unit after that edge. For delayed posts it counts edges until irq_o rises and compares that count with the expected latency. For merged requests it checks that irq_o is still low one edge before the expected firing edge and high at that edge.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;
  localparam int STAT_W       = 32;
  localparam int NUM_SRC      = 9;
  localparam int SRC_SOFT     = 0;
  localparam int SRC_RX_PKT   = 1;
  localparam int SRC_RX_HIGH  = 2;
  localparam int SRC_RX_EMPTY = 3;
  localparam int SRC_RX_DMA   = 4;
  localparam int SRC_TX_PKT   = 5;
  localparam int SRC_TX_LOW   = 6;
  localparam int SRC_TX_FULL  = 7;
  localparam int SRC_TX_DMA   = 8;
  localparam logic [STAT_W-1:0] LEGAL_BITS = STAT_W'((64'd1 << NUM_SRC) - 64'd1);
  localparam logic [STAT_W-1:0] NODLY_BITS = (STAT_W'(1) << SRC_SOFT) | (STAT_W'(1) << SRC_TX_FULL);
  localparam logic [STAT_W-1:0] MASK_RST   = (STAT_W'(1) << SRC_SOFT) | (STAT_W'(1) << SRC_RX_PKT) |
                                             (STAT_W'(1) << SRC_RX_HIGH) | (STAT_W'(1) << SRC_TX_LOW);
endpackage

// File: rtl/irq_stat_bank.sv
module irq_stat_bank #(
  parameter int              W        = 32,
  parameter int              SOFT_BIT = 0,
  parameter logic [W-1:0]    LEGAL    = '1,
  parameter logic [W-1:0]    RST_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         post_valid,
  input  logic [W-1:0] post_bits,
  input  logic         soft_cmd,
  input  logic         clr_we,
  input  logic [W-1:0] clr_data,
  input  logic         mask_we,
  input  logic [W-1:0] mask_data,
  output logic [W-1:0] status_q,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] status_n,
  output logic [W-1:0] mask_n,
  output logic         post_evt,
  output logic         mask_chg,
  output logic         rsv_err_q
);
  logic [W-1:0] set_bits, clr_bits;
  logic         rsv_err_d;

  always_comb begin
    set_bits  = (post_valid ? (post_bits & LEGAL) : '0) |
                (soft_cmd ? (W'(1) << SOFT_BIT) : '0);
    clr_bits  = clr_we ? (clr_data & LEGAL) : '0;
    status_n  = (status_q | set_bits) & ~clr_bits;
    mask_n    = mask_we ? mask_data : mask_q;
    post_evt  = |set_bits;
    mask_chg  = mask_we && (mask_data != mask_q);
    rsv_err_d = (post_valid && |(post_bits & ~LEGAL)) ||
                (clr_we && |(clr_data & ~LEGAL));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q  <= '0;
      mask_q    <= RST_MASK;
      rsv_err_q <= 1'b0;
    end else begin
      status_q  <= status_n;
      mask_q    <= mask_n;
      rsv_err_q <= rsv_err_d;
    end
  end
endmodule

// File: rtl/irq_wm_arm.sv
module irq_wm_arm #(
  parameter logic ARM_RST = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic rearm_ev,
  input  logic consume,
  output logic armed_q
);
  always_ff @(posedge clk) begin
    if (rst)           armed_q <= ARM_RST;
    else if (rearm_ev) armed_q <= 1'b1;
    else if (consume)  armed_q <= 1'b0;
  end
endmodule

// File: rtl/irq_wm_gate.sv
module irq_wm_gate #(
  parameter int W       = 32,
  parameter int RXH_BIT = 2,
  parameter int TXL_BIT = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         post_evt,
  input  logic [W-1:0] masked_n,
  input  logic         rx_empty_ev,
  input  logic         tx_full_ev,
  output logic [W-1:0] fwd_set
);
  localparam int NWM = 2;
  localparam int WM_BIT [NWM] = '{RXH_BIT, TXL_BIT};
  localparam logic [NWM-1:0] WM_ARM_RST = 2'b01;

  logic [NWM-1:0] rearm, armed, consume;
  assign rearm = {tx_full_ev, rx_empty_ev};

  for (genvar g = 0; g < NWM; g++) begin : g_wm
    assign consume[g] = post_evt && masked_n[WM_BIT[g]] && armed[g];
    irq_wm_arm #(.ARM_RST(WM_ARM_RST[g])) u_arm (
      .clk      (clk),
      .rst      (rst),
      .rearm_ev (rearm[g]),
      .consume  (consume[g]),
      .armed_q  (armed[g])
    );
  end

  always_comb begin
    fwd_set = masked_n;
    for (int i = 0; i < NWM; i++) begin
      if (!armed[i]) fwd_set[WM_BIT[i]] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_sched.sv
module irq_sched #(
  parameter int           W     = 32,
  parameter int           DLY_W = 16,
  parameter logic [W-1:0] NODLY = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             post_evt,
  input  logic [W-1:0]     fwd_set,
  input  logic [W-1:0]     masked_n,
  input  logic             mask_chg,
  input  logic             ien_we,
  input  logic             ien_data,
  input  logic             ack,
  input  logic [DLY_W-1:0] dly,
  output logic             irq_q
);
  logic             ien_q, act_q;
  logic [DLY_W-1:0] cnt_q;
  logic             ien_n, pend_d, act_d;
  logic [DLY_W-1:0] cnt_d;
  logic             want, urgent;

  always_comb begin
    ien_n  = ien_we ? ien_data : ien_q;
    want   = post_evt && |fwd_set;
    urgent = |(fwd_set & NODLY) || (dly == '0);
    pend_d = irq_q;
    act_d  = act_q;
    cnt_d  = cnt_q;
    if (ack) pend_d = 1'b0;
    if (act_q) begin
      if (cnt_q == DLY_W'(1)) begin
        pend_d = 1'b1;
        act_d  = 1'b0;
      end else begin
        cnt_d = cnt_q - DLY_W'(1);
      end
    end
    if (want && !urgent && (!act_d || cnt_d > dly)) begin
      act_d = 1'b1;
      cnt_d = dly;
    end
    if ((ien_n && !ien_q) || mask_chg || (want && urgent)) begin
      pend_d = 1'b1;
      act_d  = 1'b0;
    end
    if (!ien_n || masked_n == '0) begin
      pend_d = 1'b0;
      act_d  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q <= 1'b0;
      irq_q <= 1'b0;
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      ien_q <= ien_n;
      irq_q <= pend_d;
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/irq_coalesce_ctrl.sv
module irq_coalesce_ctrl
  import irq_coal_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              src_post_valid,
  input  logic [STAT_W-1:0] src_post_bits,
  input  logic              cmd_soft,
  input  logic              sw_clr_we,
  input  logic [STAT_W-1:0] sw_clr_data,
  input  logic              sw_mask_we,
  input  logic [STAT_W-1:0] sw_mask_data,
  input  logic              sw_ien_we,
  input  logic              sw_ien_data,
  input  logic              sw_stat_rd,
  input  logic              rx_fifo_empty_ev,
  input  logic              tx_fifo_full_ev,
  input  logic [DLY_W-1:0]  dly_cycles,
  output logic [STAT_W-1:0] stat_o,
  output logic [STAT_W-1:0] mask_o,
  output logic              irq_o,
  output logic              rsv_err_o
);
  logic [STAT_W-1:0] status_n, mask_n, masked_n, fwd_set;
  logic              post_evt, mask_chg;

  irq_stat_bank #(
    .W(STAT_W), .SOFT_BIT(SRC_SOFT), .LEGAL(LEGAL_BITS), .RST_MASK(MASK_RST)
  ) u_bank (
    .clk        (clk),
    .rst        (rst),
    .post_valid (src_post_valid),
    .post_bits  (src_post_bits),
    .soft_cmd   (cmd_soft),
    .clr_we     (sw_clr_we),
    .clr_data   (sw_clr_data),
    .mask_we    (sw_mask_we),
    .mask_data  (sw_mask_data),
    .status_q   (stat_o),
    .mask_q     (mask_o),
    .status_n   (status_n),
    .mask_n     (mask_n),
    .post_evt   (post_evt),
    .mask_chg   (mask_chg),
    .rsv_err_q  (rsv_err_o)
  );

  assign masked_n = status_n & mask_n;

  irq_wm_gate #(
    .W(STAT_W), .RXH_BIT(SRC_RX_HIGH), .TXL_BIT(SRC_TX_LOW)
  ) u_gate (
    .clk         (clk),
    .rst         (rst),
    .post_evt    (post_evt),
    .masked_n    (masked_n),
    .rx_empty_ev (rx_fifo_empty_ev),
    .tx_full_ev  (tx_fifo_full_ev),
    .fwd_set     (fwd_set)
  );

  irq_sched #(
    .W(STAT_W), .DLY_W(DLY_W), .NODLY(NODLY_BITS)
  ) u_sched (
    .clk      (clk),
    .rst      (rst),
    .post_evt (post_evt),
    .fwd_set  (fwd_set),
    .masked_n (masked_n),
    .mask_chg (mask_chg),
    .ien_we   (sw_ien_we),
    .ien_data (sw_ien_data),
    .ack      (sw_stat_rd),
    .dly      (dly_cycles),
    .irq_q    (irq_o)
  );
endmodule

// File: rtl/irq_coalesce_chk.sv
module irq_coalesce_chk #(
  parameter int           W     = 32,
  parameter logic [W-1:0] LEGAL = '1
) (
  input logic         clk,
  input logic         rst,
  input logic         post_valid,
  input logic [W-1:0] post_bits,
  input logic         soft_cmd,
  input logic         clr_we,
  input logic [W-1:0] clr_data,
  input logic         mask_we,
  input logic         ien_we,
  input logic         ien_data,
  input logic         stat_rd,
  input logic [W-1:0] stat_o,
  input logic         irq_o,
  input logic         rsv_err_o
);
  // R1
  rsv_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_o & ~LEGAL) == '0);
  // R1
  rsv_flag_chk: assert property (@(posedge clk) disable iff (rst)
    post_valid && |(post_bits & ~LEGAL) |=> rsv_err_o);
  // R2
  clr_bits_chk: assert property (@(posedge clk) disable iff (rst)
    clr_we && !post_valid && !soft_cmd |=> (stat_o & $past(clr_data)) == '0);
  // R9
  rd_keeps_stat_chk: assert property (@(posedge clk) disable iff (rst)
    stat_rd && !post_valid && !soft_cmd && !clr_we |=> $stable(stat_o));
  // R10
  irq_drop_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_o) |-> $past(stat_rd || clr_we || mask_we || ien_we));
  // R4
  ien_off_chk: assert property (@(posedge clk) disable iff (rst)
    ien_we && !ien_data |=> !irq_o);
  // R11
  soft_post_chk: assert property (@(posedge clk) disable iff (rst)
    soft_cmd && !clr_we |=> stat_o[0]);
endmodule

bind irq_coalesce_ctrl irq_coalesce_chk #(
  .W(irq_coal_pkg::STAT_W), .LEGAL(irq_coal_pkg::LEGAL_BITS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .post_valid (src_post_valid),
  .post_bits  (src_post_bits),
  .soft_cmd   (cmd_soft),
  .clr_we     (sw_clr_we),
  .clr_data   (sw_clr_data),
  .mask_we    (sw_mask_we),
  .ien_we     (sw_ien_we),
  .ien_data   (sw_ien_data),
  .stat_rd    (sw_stat_rd),
  .stat_o     (stat_o),
  .irq_o      (irq_o),
  .rsv_err_o  (rsv_err_o)
);

// File: tb/tb_irq_coalesce_ctrl.sv
`timescale 1ns/100ps
module tb_irq_coalesce_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        src_post_valid, cmd_soft, sw_clr_we, sw_mask_we, sw_ien_we, sw_ien_data;
  logic        sw_stat_rd, rx_fifo_empty_ev, tx_fifo_full_ev;
  logic [31:0] src_post_bits, sw_clr_data, sw_mask_data;
  logic [15:0] dly_cycles;
  logic [31:0] stat_o, mask_o;
  logic        irq_o, rsv_err_o;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  irq_coalesce_ctrl dut (
    .clk(clk), .rst(rst), .src_post_valid(src_post_valid), .src_post_bits(src_post_bits),
    .cmd_soft(cmd_soft), .sw_clr_we(sw_clr_we), .sw_clr_data(sw_clr_data),
    .sw_mask_we(sw_mask_we), .sw_mask_data(sw_mask_data), .sw_ien_we(sw_ien_we),
    .sw_ien_data(sw_ien_data), .sw_stat_rd(sw_stat_rd), .rx_fifo_empty_ev(rx_fifo_empty_ev),
    .tx_fifo_full_ev(tx_fifo_full_ev), .dly_cycles(dly_cycles), .stat_o(stat_o),
    .mask_o(mask_o), .irq_o(irq_o), .rsv_err_o(rsv_err_o)
  );

  // bits, delay, expected edges from post to irq rise (R7)
  localparam int NVEC = 7;
  localparam logic [63:0] VEC [NVEC] = '{
    {32'h0000_0002, 16'd5,  16'd5},
    {32'h0000_0010, 16'd3,  16'd3},
    {32'h0000_0001, 16'd9,  16'd0},
    {32'h0000_0080, 16'd12, 16'd0},
    {32'h0000_0020, 16'd0,  16'd0},
    {32'h0000_0100, 16'd1,  16'd1},
    {32'h0000_0008, 16'd17, 16'd17}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_post(input logic [31:0] b);
    src_post_valid = 1'b1; src_post_bits = b; step();
    src_post_valid = 1'b0; src_post_bits = '0;
  endtask
  task automatic do_clr(input logic [31:0] b);
    sw_clr_we = 1'b1; sw_clr_data = b; step();
    sw_clr_we = 1'b0; sw_clr_data = '0;
  endtask
  task automatic do_mask(input logic [31:0] m);
    sw_mask_we = 1'b1; sw_mask_data = m; step();
    sw_mask_we = 1'b0;
  endtask
  task automatic do_ien(input logic v);
    sw_ien_we = 1'b1; sw_ien_data = v; step();
    sw_ien_we = 1'b0;
  endtask
  task automatic do_ack();
    sw_stat_rd = 1'b1; step(); sw_stat_rd = 1'b0;
  endtask
  task automatic do_soft();
    cmd_soft = 1'b1; step(); cmd_soft = 1'b0;
  endtask
  task automatic pulse_rxe();
    rx_fifo_empty_ev = 1'b1; step(); rx_fifo_empty_ev = 1'b0;
  endtask
  task automatic pulse_txf();
    tx_fifo_full_ev = 1'b1; step(); tx_fifo_full_ev = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; src_post_valid = 0; src_post_bits = '0; cmd_soft = 0; sw_clr_we = 0;
    sw_clr_data = '0; sw_mask_we = 0; sw_mask_data = '0; sw_ien_we = 0; sw_ien_data = 0;
    sw_stat_rd = 0; rx_fifo_empty_ev = 0; tx_fifo_full_ev = 0; dly_cycles = '0;
    repeat (3) step();
    rst = 1'b0;
    step();

    // R3 reset state
    chk("R3", "status", stat_o, 32'h0);
    chk("R3", "mask", mask_o, 32'h47);
    chk("R3", "irq", {31'b0, irq_o}, 32'h0);
    chk("R3", "rsv_err", {31'b0, rsv_err_o}, 32'h0);

    // R11 soft command, R4 enable gating
    do_soft();
    chk("R11", "soft bit", stat_o, 32'h1);
    chk("R4", "irq while disabled", {31'b0, irq_o}, 32'h0);
    repeat (3) step();
    chk("R4", "irq still low", {31'b0, irq_o}, 32'h0);
    do_ien(1'b1);
    chk("R4", "enable raises", {31'b0, irq_o}, 32'h1);
    do_ien(1'b0);
    chk("R10", "disable drops", {31'b0, irq_o}, 32'h0);
    do_ien(1'b1);
    chk("R4", "re-enable raises", {31'b0, irq_o}, 32'h1);
    do_clr(32'h1FF);
    chk("R10", "clear to zero drops", {31'b0, irq_o}, 32'h0);

    // R1 reserved bits
    do_post(32'h8000_0002);
    chk("R1", "reserved dropped", stat_o, 32'h2);
    chk("R1", "rsv flag", {31'b0, rsv_err_o}, 32'h1);
    chk("R7", "zero delay immediate", {31'b0, irq_o}, 32'h1);
    step();
    chk("R1", "rsv flag one cycle", {31'b0, rsv_err_o}, 32'h0);
    sw_clr_we = 1'b1; sw_clr_data = 32'h4000_0000; step(); sw_clr_we = 1'b0; sw_clr_data = '0;
    chk("R1", "rsv flag on clear", {31'b0, rsv_err_o}, 32'h1);

    // R9 acknowledge
    do_ack();
    chk("R9", "ack drops irq", {31'b0, irq_o}, 32'h0);
    chk("R9", "ack keeps status", stat_o, 32'h2);
    step();
    chk("R9", "stays low", {31'b0, irq_o}, 32'h0);
    do_post(32'h1);
    chk("R9", "new post after ack", {31'b0, irq_o}, 32'h1);
    do_clr(32'h1);
    chk("R2", "clear one bit", stat_o, 32'h2);
    chk("R2", "irq kept", {31'b0, irq_o}, 32'h1);
    do_mask(32'h1);
    chk("R10", "mask hides all", {31'b0, irq_o}, 32'h0);
    do_mask(32'h47);
    chk("R10", "mask reveals", {31'b0, irq_o}, 32'h1);
    do_clr(32'h1FF);

    // R5 receive-high arming
    do_post(32'h4);
    chk("R5", "armed forwards", {31'b0, irq_o}, 32'h1);
    do_ack(); do_clr(32'h1FF);
    do_post(32'h4);
    chk("R5", "status recorded", stat_o, 32'h4);
    chk("R5", "disarmed suppressed", {31'b0, irq_o}, 32'h0);
    step();
    chk("R5", "still suppressed", {31'b0, irq_o}, 32'h0);
    do_clr(32'h1FF);
    pulse_rxe();
    do_post(32'h4);
    chk("R5", "re-armed forwards", {31'b0, irq_o}, 32'h1);
    do_clr(32'h1FF);

    // R6 transmit-low arming
    do_post(32'h40);
    chk("R6", "disarmed at reset", {31'b0, irq_o}, 32'h0);
    do_clr(32'h1FF);
    pulse_txf();
    do_post(32'h40);
    chk("R6", "armed after full", {31'b0, irq_o}, 32'h1);
    do_clr(32'h1FF);

    // R7 latency table
    do_mask(32'h1FF);
    do_clr(32'h1FF);
    for (int v = 0; v < NVEC; v++) begin
      int lat;
      dly_cycles = VEC[v][31:16];
      do_post(VEC[v][63:32]);
      chk("R7", "status", stat_o, VEC[v][63:32]);
      lat = 0;
      while (!irq_o && lat < 40) begin
        step();
        lat++;
      end
      chk("R7", "latency", 32'(lat), {16'b0, VEC[v][15:0]});
      do_clr(32'h1FF);
    end

    // R8 later request merged into earlier one
    dly_cycles = 16'd4;
    do_post(32'h2);
    dly_cycles = 16'd30;
    do_post(32'h10);
    step(); step();
    chk("R8", "not yet", {31'b0, irq_o}, 32'h0);
    step();
    chk("R8", "earlier covers", {31'b0, irq_o}, 32'h1);
    do_clr(32'h1FF);

    // R8 sooner request replaces
    dly_cycles = 16'd20;
    do_post(32'h2);
    repeat (4) step();
    dly_cycles = 16'd3;
    do_post(32'h10);
    step(); step();
    chk("R8", "not yet", {31'b0, irq_o}, 32'h0);
    step();
    chk("R8", "sooner replaces", {31'b0, irq_o}, 32'h1);
    do_clr(32'h1FF);

    summary();
    $finish;
  end
endmodule